// File: doc/BRIEF.md
# Lock-in Up/Down Decimator

This block turns the two event lines of a three-level pulse-density modulator into a signed digital sample that carries only the component in phase with an external lock-in reference square wave. One line pulses for positive events and the other for negative events; at most one of them pulses at a time. Demodulation happens in the pulse domain. While the reference is high, a positive event counts up and a negative event counts down. While it is low, the two roles are swapped. No multiplication is involved.

The counted events feed a signed saturating up/down accumulator. Over an acquisition window it acts as a first-order low-pass decimator. The window length is a programmable number of reference periods. The window opens on the first rising reference edge after reset or `init`. When the window closes, the count is latched into `sample_o`, `valid_o` pulses for one clock cycle, and counting restarts from zero for the next window. The pulse lines and the reference come from other clock domains, so each one passes through a synchroniser. Each pulse is counted once, on its rising edge, however many clock cycles it lasts.

Top module: `lockin_updown_decim`

## Requirements
- R1: While `rst_n` is low or `init` is high, `sample_o` is 0 and `valid_o` is 0. The accumulator is cleared, and a window in progress is discarded without producing a sample.
- R2: While the reference is high, a positive event adds 1 to the count and a negative event subtracts 1.
- R3: While the reference is low, a positive event subtracts 1 from the count and a negative event adds 1.
- R4: A pulse counts exactly once, on its rising edge, whether it stays high for one clock cycle or for many.
- R5: If positive and negative events are detected in the same cycle, the count does not change.
- R6: A window spans `win_len_i` rising reference edges after the edge that opened it. A `win_len_i` of 0 acts as 1.
- R7: When a window closes, `sample_o` takes the window's count and `valid_o` is high for exactly one cycle. The next window starts from zero. An event detected in the cycle of the closing edge belongs to the closing window and uses the new high phase. `sample_o` holds its value until the next close.
- R8: The count saturates at +2^(CNT_W-1)-1 and -2^(CNT_W-1) instead of wrapping. An opposite event moves it back off the limit.
- R9: After reset or `init`, events are ignored until the first rising reference edge, which only opens a window and closes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous conversion restart, active high |
| pos_i | input | 1 | Positive event pulse line (asynchronous) |
| neg_i | input | 1 | Negative event pulse line (asynchronous) |
| ref_i | input | 1 | Lock-in reference square wave (asynchronous) |
| win_len_i | input | LEN_W | Window length in reference periods (0 means 1) |
| sample_o | output | CNT_W | Signed two's complement sample of the last closed window |
| valid_o | output | 1 | One-cycle strobe when a new sample is present |

## Verification
The close of a window and a counted event can land in the same clock cycle. The bench provokes this by raising the reference line and a positive pulse line together. Both inputs pass through synchronisers of equal depth, so the DUT sees the reference edge and the pulse edge in the same cycle. The result is judged by the scoreboard: the closing window must include that event, counted with the high-phase sign, and the following window must start from zero. The same-cycle coincidence of positive and negative events is also provoked and must leave the count unchanged.

// File: rtl/lid_pkg.sv
package lid_pkg;

    typedef enum logic {
        WIN_ARM = 1'b0,
        WIN_RUN = 1'b1
    } win_state_e;

endpackage

// File: rtl/lid_sync_edge.sv
module lid_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sh   = {r_q.sh[STAGES-2:0], d_i};
        r_d.last = r_q.sh[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lvl_o  = r_q.sh[TOP];
    assign rise_o = r_q.sh[TOP] & ~r_q.last;
endmodule

// File: rtl/lid_xroute.sv
module lid_xroute (
    input  logic pos_ev,
    input  logic neg_ev,
    input  logic phase,
    output logic up_ev,
    output logic dn_ev
);
    logic single;

    always_comb begin
        single = pos_ev ^ neg_ev;
        if (phase) begin
            up_ev = single & pos_ev;
            dn_ev = single & neg_ev;
        end else begin
            up_ev = single & neg_ev;
            dn_ev = single & pos_ev;
        end
    end
endmodule

// File: rtl/lid_sat_acc.sv
module lid_sat_acc #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         up_ev,
    input  logic         dn_ev,
    output logic [W-1:0] count_q,
    output logic [W-1:0] count_nx
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_d;

    always_comb begin
        count_nx = count_q;
        if (en && (up_ev ^ dn_ev)) begin
            if (up_ev && count_q != MAXV)      count_nx = count_q + ONE;
            else if (dn_ev && count_q != MINV) count_nx = count_q - ONE;
        end
        count_d = clr ? '0 : count_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end
endmodule

// File: rtl/lid_window.sv
module lid_window
    import lid_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             ref_rise,
    input  logic [LEN_W-1:0] len_i,
    output logic             run_o,
    output logic             close_o
);
    localparam logic [LEN_W:0] ONE_X = {{LEN_W{1'b0}}, 1'b1};

    typedef struct packed {
        win_state_e       st;
        logic [LEN_W-1:0] per;
    } win_t;

    win_t w_d, w_q;
    logic [LEN_W:0] eff_len;
    logic [LEN_W:0] per_inc;

    always_comb begin
        w_d     = w_q;
        close_o = 1'b0;
        eff_len = (len_i == '0) ? ONE_X : {1'b0, len_i};
        per_inc = {1'b0, w_q.per} + ONE_X;
        if (init) begin
            w_d.st  = WIN_ARM;
            w_d.per = '0;
        end else if (ref_rise) begin
            if (w_q.st == WIN_ARM) begin
                w_d.st  = WIN_RUN;
                w_d.per = '0;
            end else if (per_inc >= eff_len) begin
                close_o = 1'b1;
                w_d.per = '0;
            end else begin
                w_d.per = per_inc[LEN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: WIN_ARM, per: '0};
        else        w_q <= w_d;
    end

    assign run_o = (w_q.st == WIN_RUN);
endmodule

// File: rtl/lockin_updown_decim.sv
module lockin_updown_decim #(
    parameter int CNT_W       = 24,
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             pos_i,
    input  logic             neg_i,
    input  logic             ref_i,
    input  logic [LEN_W-1:0] win_len_i,
    output logic [CNT_W-1:0] sample_o,
    output logic             valid_o
);
    localparam int N_LINES = 3;

    typedef struct packed {
        logic [CNT_W-1:0] sample;
        logic             valid;
    } out_t;

    logic [N_LINES-1:0] raw_w, lvl_w, rise_w;
    logic               pos_ev, neg_ev, ref_lvl, ref_rise;
    logic               up_ev, dn_ev;
    logic               win_run, win_close, acc_en, acc_clr;
    logic [CNT_W-1:0]   acc_q, acc_nx;
    out_t               o_d, o_q;

    assign raw_w = {ref_i, neg_i, pos_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        lid_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (raw_w[g]),
            .lvl_o  (lvl_w[g]),
            .rise_o (rise_w[g])
        );
    end

    assign pos_ev   = rise_w[0];
    assign neg_ev   = rise_w[1];
    assign ref_lvl  = lvl_w[2];
    assign ref_rise = rise_w[2];

    lid_xroute u_route (
        .pos_ev (pos_ev),
        .neg_ev (neg_ev),
        .phase  (ref_lvl),
        .up_ev  (up_ev),
        .dn_ev  (dn_ev)
    );

    lid_window #(.LEN_W(LEN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .ref_rise (ref_rise),
        .len_i    (win_len_i),
        .run_o    (win_run),
        .close_o  (win_close)
    );

    assign acc_en  = win_run & ~init;
    assign acc_clr = win_close | init;

    lid_sat_acc #(.W(CNT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (acc_en),
        .clr      (acc_clr),
        .up_ev    (up_ev),
        .dn_ev    (dn_ev),
        .count_q  (acc_q),
        .count_nx (acc_nx)
    );

    always_comb begin
        o_d = o_q;
        if (init) begin
            o_d = '0;
        end else begin
            o_d.valid = win_close;
            if (win_close) o_d.sample = acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign sample_o = o_q.sample;
    assign valid_o  = o_q.valid;
endmodule

// File: rtl/lid_checker.sv
module lid_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             valid_o,
    input logic [CNT_W-1:0] sample_o,
    input logic [2:0]       lvl_w,
    input logic [2:0]       rise_w,
    input logic             ref_lvl,
    input logic             up_ev,
    input logic             dn_ev,
    input logic             acc_en,
    input logic             win_close,
    input logic [CNT_W-1:0] acc_q
);
    localparam logic [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};

    // R1
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (sample_o == '0 && !valid_o));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_o) |-> (valid_o || $past(init)));

    // R2
    high_phase_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_lvl && rise_w[0] && !rise_w[1]) |-> (up_ev && !dn_ev));

    // R3
    low_phase_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_lvl && rise_w[0] && !rise_w[1]) |-> (dn_ev && !up_ev));

    // R5
    coincident_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w[0] && rise_w[1]) |-> (!up_ev && !dn_ev));

    // R4
    held_pos_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_w[0] && $past(lvl_w[0])) |-> !rise_w[0]);

    // R4
    held_neg_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_w[1] && $past(lvl_w[1])) |-> !rise_w[1]);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == MAXV && up_ev && !dn_ev && acc_en && !win_close && !init)
        |=> acc_q == MAXV);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == MINV && dn_ev && !up_ev && acc_en && !win_close && !init)
        |=> acc_q == MINV);

    // R9
    arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !init && !win_close) |=> $stable(acc_q));
endmodule

bind lockin_updown_decim lid_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .valid_o   (valid_o),
    .sample_o  (sample_o),
    .lvl_w     (lvl_w),
    .rise_w    (rise_w),
    .ref_lvl   (ref_lvl),
    .up_ev     (up_ev),
    .dn_ev     (dn_ev),
    .acc_en    (acc_en),
    .win_close (win_close),
    .acc_q     (acc_q)
);

// File: tb/lockin_updown_decim_test.sv
module lockin_updown_decim_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int LEN_W      = 8;
    localparam int MAXV       = (1 << (CNT_W - 1)) - 1;
    localparam int MINV       = -(1 << (CNT_W - 1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init = 1'b0;
    logic             pos_i = 1'b0;
    logic             neg_i = 1'b0;
    logic             ref_i = 1'b0;
    logic [LEN_W-1:0] win_len_i = '0;
    logic [CNT_W-1:0] sample_o;
    logic             valid_o;

    int n_vec = 0;
    int n_bad = 0;
    int exp_q[$];
    int model = 0;
    int pcnt = 0;
    bit armed = 1'b0;
    bit ref_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockin_updown_decim #(.CNT_W(CNT_W), .LEN_W(LEN_W), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (init),
        .pos_i     (pos_i),
        .neg_i     (neg_i),
        .ref_i     (ref_i),
        .win_len_i (win_len_i),
        .sample_o  (sample_o),
        .valid_o   (valid_o)
    );

    function automatic int eff_len();
        return (win_len_i == '0) ? 1 : int'(win_len_i);
    endfunction

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_event(bit p, bit n);
        int d;
        if (!armed || (p && n)) return;          // R9, R5
        d = p ? 1 : -1;
        if (!ref_m) d = -d;                     // R2 / R3
        model = model + d;
        if (model > MAXV) model = MAXV;         // R8
        if (model < MINV) model = MINV;
    endtask

    task automatic pulse(bit p, bit n, int w);
        @(negedge clk);
        pos_i = p; neg_i = n;
        model_event(p, n);
        repeat (w) @(negedge clk);
        pos_i = 1'b0; neg_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ref_rise_model();
        if (!armed) begin
            armed = 1'b1; model = 0; pcnt = 0;  // R9 opening edge
        end else begin
            pcnt++;
            if (pcnt >= eff_len()) begin        // R6
                exp_q.push_back(model);         // R7
                model = 0; pcnt = 0;
            end
        end
    endtask

    task automatic set_ref(bit v);
        repeat (4) @(negedge clk);
        ref_i = v;
        if (v) ref_rise_model();
        ref_m = v;
        repeat (4) @(negedge clk);
    endtask

    // reference rises together with a positive pulse (R7 coincidence)
    task automatic rise_with_pulse();
        repeat (4) @(negedge clk);
        ref_i = 1'b1; pos_i = 1'b1;
        ref_m = 1'b1;
        model_event(1'b1, 1'b0);
        ref_rise_model();
        repeat (2) @(negedge clk);
        pos_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R7: actual valid with sample %0d expected no valid",
                         $signed(sample_o));
            end else begin
                check("R7 window sample", int'($signed(sample_o)), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 reset sample", int'(sample_o), 0);
        check("R1 reset valid", int'(valid_o), 0);
        rst_n = 1'b1;
        win_len_i = 8'd2;
        // R9: events before the opening edge are ignored
        pulse(1, 0, 3);
        pulse(0, 1, 3);
        set_ref(1);
        // window A, two periods: R2 R3 R4 R5
        pulse(1, 0, 1); pulse(1, 0, 1); pulse(1, 0, 1);
        pulse(0, 1, 5);
        set_ref(0);
        pulse(1, 0, 1);
        pulse(0, 1, 1); pulse(0, 1, 1); pulse(0, 1, 1); pulse(0, 1, 1);
        set_ref(1);
        pulse(1, 1, 3);                    // R5
        pulse(1, 0, 8);                    // R4 long pulse
        set_ref(0);
        pulse(1, 0, 1); pulse(1, 0, 1);
        set_ref(1);                        // closes A: expect 4
        // window B: ends with an event on the closing edge
        for (int i = 0; i < 5; i++) pulse(0, 1, 2);
        set_ref(0);
        pulse(1, 0, 2); pulse(1, 0, 2);
        set_ref(1);
        set_ref(0);
        rise_with_pulse();                 // closes B: expect -6
        // window C is abandoned by init (R1)
        pulse(1, 0, 1); pulse(1, 0, 1); pulse(1, 0, 1);
        set_ref(0);
        @(negedge clk);
        init = 1'b1;
        win_len_i = '0;                    // R6: zero acts as one
        repeat (3) @(negedge clk);
        check("R1 init sample", int'(sample_o), 0);
        check("R1 init valid", int'(valid_o), 0);
        init = 1'b0;
        armed = 1'b0;
        pulse(1, 0, 2);                    // R9 ignored
        set_ref(1);
        // window D
        pulse(1, 0, 1); pulse(1, 0, 1);
        set_ref(0);
        pulse(0, 1, 1);
        set_ref(1);                        // expect 3
        // window E: positive saturation R8
        for (int i = 0; i < 40; i++) pulse(1, 0, 1);
        for (int i = 0; i < 3; i++) pulse(0, 1, 1);
        set_ref(0);
        set_ref(1);                        // expect 28
        // window F: negative saturation R8
        set_ref(0);
        for (int i = 0; i < 40; i++) pulse(1, 0, 1);
        for (int i = 0; i < 2; i++) pulse(0, 1, 1);
        set_ref(1);                        // expect -30
        // window G: empty
        set_ref(0);
        set_ref(1);                        // expect 0
        repeat (12) @(negedge clk);
        check("R7 sample held", int'($signed(sample_o)), 0);
        check("R7 all windows delivered", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule